// File: doc/BRIEF.md
# Mode-Selectable Sequence Counter

This block is a four-bit state counter that steps through one of four repeating sequences, chosen by a two-bit mode input. The sequences are not hand-coded next-state tables. A loadable up/down counter core holds the value, and a small feedback stage drives its direction, load strobe and load data from the core's own value and terminal-count flag. The output is the counter value itself. A typical use is as a sequence generator or a step counter for a larger controller that needs a non-binary order.

The modes are named states of the feedback stage:

- **FOLD** (`2'b00`) counts down from 7 to 0, jumps to 8, counts up to 15, then jumps back to 7. Direction follows the top bit. The load fires on terminal count and inverts the top bit.
- **OFFSET** (`2'b01`) counts up and reloads 6 when it passes 15, so it never returns below 6.
- **TRUNC** (`2'b10`) counts up and reloads 0 once it has reached 12.
- **MOD6** (`2'b11`) cycles 0 to 5 on the low three bits with the top bit held low. Every state outside that cycle is sent back into it on the next edge, so the counter starts itself from any value.

Transitions: a synchronous reset loads the first value of the selected sequence. Each clock edge without reset applies the selected mode's step. A mode change takes effect on the next edge, starting from whatever value the counter holds at that moment.

Top module: `modal_seq_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next value is the first value of the selected sequence: 7 for FOLD, 6 for OFFSET, 0 for TRUNC and 0 for MOD6.
- R2: Mode encoding on `mode`: 2'b00 FOLD, 2'b01 OFFSET, 2'b10 TRUNC, 2'b11 MOD6.
- R3: In FOLD, a value from 1 to 7 steps down by one, and a value from 8 to 14 steps up by one.
- R4: In FOLD, 0 is followed by 8 and 15 is followed by 7, so that the period is 16.
- R5: In OFFSET, the value steps up by one, and 15 is followed by 6.
- R6: In TRUNC, 12 is followed by 0. Any other value steps up by one, and 15 wraps to 0.
- R7: In MOD6, values 0 to 4 step up by one and 5 is followed by 0, with q[3] at 0.
- R8: In MOD6, a value whose low three bits are 110 or 111 is followed by 0. A value with q[3]=1 is followed by the next ring value of its low three bits (low bits 0 to 4 add one, 5 to 7 give 0), with q[3] cleared.
- R9: A mode change applies from the current value at the next edge. With the mode held, the value enters the selected cycle within 16 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Sequence select (see R2) |
| q | output | 4 | Counter value |

## Verification
Every result of this block appears one rising edge after the inputs that cause it. That includes the reset start value, each sequence step and the first step after a mode change. The bench changes `rst` and `mode` only on falling edges. At each rising edge it advances its behavioural model, using the mode and reset it has just applied. It then compares `q` at the following falling edge, so every comparison is exactly one edge after its cause.

The entry check after a mode change counts edges one at a time, up to sixteen. It reports a failure if the value is still outside the chosen cycle after the last of them. Entry into the unused MOD6 states is forced from the ports: the bench runs FOLD to 7, 9, 14 or 15 and then selects MOD6.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

    typedef enum logic [1:0] {
        SEQ_FOLD   = 2'b00,
        SEQ_OFFSET = 2'b01,
        SEQ_TRUNC  = 2'b10,
        SEQ_MOD6   = 2'b11
    } seq_mode_e;

    typedef struct packed {
        logic up;
        logic load;
    } core_ctl_t;

endpackage

// File: rtl/seqctr_updown.sv
module seqctr_updown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rst_val,
    input  logic         up,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] q_next;

    always_comb begin
        if (load)
            q_next = din;
        else if (up)
            q_next = q + ONE;
        else
            q_next = q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= rst_val;
        else
            q <= q_next;
    end

    // Terminal count: top of range when counting up, zero when counting down.
    assign tc = up ? (&q) : ~(|q);

    assert_core_up_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && up) |=> (q == $past(q) + ONE));

    assert_core_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !up) |=> (q == $past(q) - ONE));

    assert_core_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));

endmodule

// File: rtl/seqctr_feedback.sv
module seqctr_feedback
    import seqctr_pkg::*;
#(
    parameter int W          = 4,
    parameter int WRAP_BASE  = 6,
    parameter int TRUNC_LAST = 12,
    parameter int RING_LEN   = 6
) (
    input  seq_mode_e    mode,
    input  logic [W-1:0] q,
    input  logic         tc,
    output logic         up,
    output logic         load,
    output logic [W-1:0] din,
    output logic [W-1:0] rst_val
);

    localparam int SUB_W = $clog2(RING_LEN);
    localparam int HALF  = 1 << (W - 1);
    localparam logic [W-1:0]     FOLD_FIRST = W'(HALF - 1);
    localparam logic [W-1:0]     WRAP_VAL   = W'(WRAP_BASE);
    localparam logic [W-1:0]     TRUNC_VAL  = W'(TRUNC_LAST);
    localparam logic [SUB_W-1:0] RING_LASTV = SUB_W'(RING_LEN - 1);

    logic [SUB_W-1:0] ring_lo;
    logic [SUB_W-1:0] ring_inc;
    logic             ring_hi_set;
    logic             ring_end;
    core_ctl_t        ctl;

    assign ring_lo     = q[SUB_W-1:0];
    assign ring_hi_set = |q[W-1:SUB_W];
    assign ring_end    = (ring_lo >= RING_LASTV);
    assign ring_inc    = ring_end ? '0 : ring_lo + SUB_W'(1);

    always_comb begin
        ctl     = '{up: 1'b1, load: 1'b0};
        din     = '0;
        rst_val = '0;
        unique case (mode)
            SEQ_FOLD: begin
                ctl.up   = q[W-1];
                ctl.load = tc;
                din      = {~q[W-1], q[W-2:0]};
                rst_val  = FOLD_FIRST;
            end
            SEQ_OFFSET: begin
                ctl.load = tc;
                din      = WRAP_VAL;
                rst_val  = WRAP_VAL;
            end
            SEQ_TRUNC: begin
                ctl.load = (q == TRUNC_VAL);
                din      = '0;
                rst_val  = '0;
            end
            SEQ_MOD6: begin
                ctl.load = ring_hi_set | ring_end;
                din      = {{(W-SUB_W){1'b0}}, ring_inc};
                rst_val  = '0;
            end
            default: begin
                ctl     = '{up: 1'b1, load: 1'b0};
                din     = '0;
                rst_val = '0;
            end
        endcase
    end

    assign up   = ctl.up;
    assign load = ctl.load;

    always_comb begin
        if (mode == SEQ_MOD6)
            assert_ring_data_R8: assert (din < W'(RING_LEN));
    end

endmodule

// File: rtl/modal_seq_counter.sv
module modal_seq_counter
    import seqctr_pkg::*;
#(
    parameter int W          = 4,
    parameter int WRAP_BASE  = 6,
    parameter int TRUNC_LAST = 12,
    parameter int RING_LEN   = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    output logic [W-1:0] q
);

    localparam int ENTRY_LIMIT = 1 << W;
    localparam int CNT_W       = $clog2(ENTRY_LIMIT) + 1;
    localparam int HALF        = 1 << (W - 1);
    localparam logic [W-1:0] TOPV = {W{1'b1}};

    seq_mode_e    mode_e;
    logic         c_up;
    logic         c_load;
    logic         c_tc;
    logic [W-1:0] c_din;
    logic [W-1:0] c_rst_val;

    assign mode_e = seq_mode_e'(mode);

    seqctr_feedback #(
        .W(W), .WRAP_BASE(WRAP_BASE), .TRUNC_LAST(TRUNC_LAST), .RING_LEN(RING_LEN)
    ) u_feedback (
        .mode    (mode_e),
        .q       (q),
        .tc      (c_tc),
        .up      (c_up),
        .load    (c_load),
        .din     (c_din),
        .rst_val (c_rst_val)
    );

    seqctr_updown #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .rst_val (c_rst_val),
        .up      (c_up),
        .load    (c_load),
        .din     (c_din),
        .q       (q),
        .tc      (c_tc)
    );

    // Entry-window monitor for the checks below.
    logic             in_cycle;
    logic [CNT_W-1:0] stray_cnt;
    logic [1:0]       mode_q;
    logic             rst_q;

    always_comb begin
        unique case (mode_e)
            SEQ_FOLD:   in_cycle = 1'b1;
            SEQ_OFFSET: in_cycle = (q >= W'(WRAP_BASE));
            SEQ_TRUNC:  in_cycle = (q <= W'(TRUNC_LAST));
            SEQ_MOD6:   in_cycle = (q <  W'(RING_LEN));
            default:    in_cycle = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        mode_q <= mode;
        rst_q  <= rst;
        if (rst || (mode != mode_q) || in_cycle)
            stray_cnt <= '0;
        else if (stray_cnt != {CNT_W{1'b1}})
            stray_cnt <= stray_cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_start_R1: assert (q == ((mode_q == 2'b00) ? W'(HALF - 1) :
                                                 (mode_q == 2'b01) ? W'(WRAP_BASE) : W'(0)));
        end
    end

    assert_fold_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && q == '0) |=> (q == W'(HALF)));

    assert_fold_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && q == TOPV) |=> (q == W'(HALF - 1)));

    assert_fold_descend_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && q != '0 && !q[W-1]) |=> (q == $past(q) - W'(1)));

    assert_wrap_base_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && q == TOPV) |=> (q == W'(WRAP_BASE)));

    assert_trunc_last_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && q == W'(TRUNC_LAST)) |=> (q == '0));

    assert_ring_range_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> (q < W'(RING_LEN)));

    assert_ring_recover_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && q[2:1] == 2'b11) |=> (q == '0));

    assert_entry_window_R9: assert property (@(posedge clk) disable iff (rst)
        stray_cnt < CNT_W'(ENTRY_LIMIT));

endmodule

// File: tb/modal_seq_counter_tb.sv
module modal_seq_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [3:0] q;

    int    ref_q     = 0;
    int    prev_mode = 0;
    int    vec       = 0;
    int    miss      = 0;
    bit    done      = 1'b0;
    string tag;

    always #10 clk = ~clk;

    modal_seq_counter u_dut (.clk(clk), .rst(rst), .mode(mode), .q(q));

    function automatic int start_of(int m);
        case (m)
            0: return 7;
            1: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic int nxt(int m, int v);
        case (m)
            0: begin
                if (v == 0) return 8;
                if (v == 15) return 7;
                return (v >= 8) ? v + 1 : v - 1;
            end
            1: return (v == 15) ? 6 : v + 1;
            2: return (v == 12) ? 0 : (v + 1) % 16;
            default: return ((v % 8) >= 5) ? 0 : (v % 8) + 1;
        endcase
    endfunction

    function automatic bit in_cycle(int m, int v);
        case (m)
            0: return 1'b1;
            1: return v >= 6;
            2: return v <= 12;
            default: return v < 6;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            tag   = "R1 R2";
            ref_q = start_of(int'(mode));
        end else begin
            case (int'(mode))
                0: tag = (ref_q == 0 || ref_q == 15) ? "R4" : "R3";
                1: tag = "R5";
                2: tag = "R6";
                default: tag = (ref_q >= 8 || (ref_q % 8) >= 6) ? "R8" : "R7";
            endcase
            if (int'(mode) != prev_mode && tag != "R8") tag = "R9";
            ref_q = nxt(int'(mode), ref_q);
        end
        prev_mode = int'(mode);
        @(negedge clk);
        vec++;
        if (q !== 4'(ref_q)) begin
            miss++;
            $display("FAIL %s mode=%0d actual=%0d expected=%0d", tag, mode, q, ref_q);
        end
    endtask

    task automatic do_reset(int m);
        mode = 2'(m);
        rst  = 1'b1;
        tick();
        tick();
        rst  = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_until(int v);
        for (int i = 0; i < 40 && ref_q != v; i++) tick();
    endtask

    task automatic entry(int m);
        bit ok;
        ok   = 1'b0;
        mode = 2'(m);
        for (int i = 0; i < 16; i++) begin
            tick();
            if (in_cycle(m, int'(q))) begin
                ok = 1'b1;
                break;
            end
        end
        vec++;
        if (!ok) begin
            miss++;
            $display("FAIL R9 entry mode=%0d actual=%0d expected=in-cycle", m, q);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Reset and full runs per mode (R1 R2 R3 R4 R5 R6 R7)
        do_reset(0); run(40);
        do_reset(1); run(30);
        do_reset(2); run(30);
        do_reset(3); run(20);
        // Forced entry into unused MOD6 states (R8)
        do_reset(0); run_until(14); mode = 2'b11; tick(); run(8);
        do_reset(0); mode = 2'b11; tick(); run(3);
        do_reset(0); run_until(15); mode = 2'b11; tick(); run(3);
        do_reset(0); run_until(9);  mode = 2'b11; tick(); run(3);
        // Mode changes from arbitrary values (R9)
        do_reset(2); entry(1); run(12);
        do_reset(0); run_until(13); entry(2); run(16);
        do_reset(0); run_until(2); entry(1); run(12);
        do_reset(3); run(3); entry(0); run(18);
        do_reset(1); run_until(14); entry(3); run(8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

endmodule